// File: doc/BRIEF.md
# Handshaked Bus Read Sequencer

This block runs word-wide read cycles for a 16-bit processor core against a memory port that answers in its own time. The core places one operation on a valid/ready request port. A read first drives an address-announce phase. The sequencer then stretches the cycle in fixed-size wait periods until the memory side terminates it. A completion phase follows, and at its end the read word is captured and handed back with a one-cycle `done` pulse. One clock cycle of the block is one half-cycle of the processor clock.

Four operations are accepted. Data reads take their address from the request. Program reads take the address from an internal program counter, which moves forward by one word once the read ends. A bus-idle operation occupies the bus for a whole number of microcycles and transfers nothing. A set-counter operation loads the program counter. The memory side can terminate a wait with any of three inputs: data acknowledge, valid peripheral address or bus error. It may also lengthen the completion phase by a small number of half-cycles. A build parameter selects implicit acknowledge for zero-wait memories. That build goes straight to the completion phase and never waits.

States: `ST_IDLE` (ready for a request), `ST_ANNOUNCE` (address strobe up, counting the announce length), `ST_WAIT` (one wait period), `ST_COMPLETE` (data phase, base length plus extra delay) and `ST_SPIN` (bus idle operation). Transitions:
- IDLE→ANNOUNCE on an accepted read, or IDLE→COMPLETE when acknowledge is implicit.
- IDLE→SPIN on an accepted idle operation with a non-zero count.
- IDLE→IDLE, with `done`, on set-counter or a zero-count idle operation.
- ANNOUNCE→COMPLETE, or WAIT→COMPLETE, when the phase ends with a terminator high.
- ANNOUNCE→WAIT, or WAIT→WAIT, when the phase ends with no terminator high.
- COMPLETE→IDLE and SPIN→IDLE when their count runs out.

Top module: `bus_read_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_as`, `bus_rd` and `done` are 0, and `pc` equals the parameter `PC_RESET` (default 0).
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge that takes a read or a non-zero idle operation until that operation finishes. A request presented while busy has no effect.
- R3: With explicit acknowledge, a read keeps `bus_as` and `bus_rd` at 1 from acceptance until it ends. The first 4 cycles form the announce phase. `bus_addr` and `bus_space` stay fixed for the whole access, with `bus_space` 0 for a data read and 1 for a program read.
- R4: The terminator inputs are sampled on the edge that ends the announce phase and on the edge that ends each wait period. When all are low, another wait period of 2 cycles follows.
- R5: `mem_dtack`, `mem_vpa` and `mem_berr` each end the wait on their own, with identical timing.
- R6: The completion phase lasts 4 cycles plus `mem_extra`, sampled on the edge that enters it. With k wait periods, `done` is 1 in the cycle that begins 8 + 2k + `mem_extra` edges after acceptance. `done_data` then holds `mem_rdata` as sampled on the last edge of the completion phase, and `bus_as` is 0.
- R7: With `IMPLICIT_ACK` set, a read goes straight to completion and ignores the terminators. `done` rises 4 + `mem_extra` edges after acceptance, with `mem_extra` sampled on the accepting edge.
- R8: `req_op` encodes 0 data read, 1 program read, 2 bus idle, 3 set counter. A program read uses `pc` as the address and adds 2 to `pc` on the edge where it finishes. A data read uses `req_addr` and leaves `pc` unchanged.
- R9: A bus-idle operation of n = `req_mc` microcycles keeps `bus_as` at 0 and raises `done` 4·n edges after acceptance. For n = 0, `done` is 1 in the cycle right after acceptance.
- R10: A set-counter operation loads `pc` from `req_addr` and raises `done` in the cycle right after acceptance.
- R11: In the cycle where `done` is 1, `req_ready` is 1, so a new request can be taken on the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half-cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code (R8) |
| req_addr | input | ADDR_W | Data read address or new counter value |
| req_mc | input | MC_W | Microcycle count for bus idle |
| mem_dtack | input | 1 | Data acknowledge terminator |
| mem_vpa | input | 1 | Valid peripheral address terminator |
| mem_berr | input | 1 | Bus error terminator |
| mem_extra | input | DELAY_W | Extra completion half-cycles |
| mem_rdata | input | DATA_W | Read data from memory |
| bus_addr | output | ADDR_W | Address of the running access |
| bus_space | output | 1 | 0 data space, 1 program space |
| bus_as | output | 1 | Address strobe |
| bus_rd | output | 1 | Read strobe |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Word returned by the last read |
| pc | output | ADDR_W | Program counter |

## Verification
Two things can fall in the same cycle: the end of one operation and the acceptance of the next. The sweep issues each request at once on the edge that ends the `done` cycle of the previous one. Every new access therefore starts while the previous completion pulse is still up. The bench judges this by checking `req_ready` in every `done` cycle. It then counts the new operation's latency from that edge. The result must match the arithmetic of R4 to R9, while terminators rise at every offset from 0 to 7 and `mem_extra` sweeps 0 to 3.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ANNOUNCE = 3'd1,
        ST_WAIT     = 3'd2,
        ST_COMPLETE = 3'd3,
        ST_SPIN     = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_DATA_RD = 2'd0,
        OP_PROG_RD = 2'd1,
        OP_BUSIDLE = 2'd2,
        OP_SET_PC  = 2'd3
    } seq_op_e;

endpackage

// File: rtl/busseq_phase_timer.sv
module busseq_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - W'(1);
    end

    assign zero = (remain == '0);
endmodule

// File: rtl/busseq_pc_unit.sv
module busseq_pc_unit #(
    parameter int          AW       = 24,
    parameter logic [AW-1:0] PC_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_val,
    input  logic          step,
    output logic [AW-1:0] pc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc <= PC_RESET;
        else if (set)
            pc <= set_val;
        else if (step)
            pc <= pc + AW'(2);
    end
endmodule

// File: rtl/bus_read_sequencer.sv
module bus_read_sequencer
    import busseq_pkg::*;
#(
    parameter int              ADDR_W         = 24,
    parameter int              DATA_W         = 16,
    parameter int              DELAY_W        = 3,
    parameter int              MC_W           = 4,
    parameter int              ANNOUNCE_HC    = 4,
    parameter int              WAIT_HC        = 2,
    parameter int              COMPLETE_HC    = 4,
    parameter int              HC_PER_MC      = 4,
    parameter bit              IMPLICIT_ACK   = 1'b0,
    parameter logic [ADDR_W-1:0] PC_RESET     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MC_W-1:0]   req_mc,
    input  logic              mem_dtack,
    input  logic              mem_vpa,
    input  logic              mem_berr,
    input  logic [DELAY_W-1:0] mem_extra,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_space,
    output logic              bus_as,
    output logic              bus_rd,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [ADDR_W-1:0] pc
);
    localparam int COMPLETE_MAX = COMPLETE_HC + (1 << DELAY_W) - 1;
    localparam int SPIN_MAX     = HC_PER_MC * ((1 << MC_W) - 1);
    localparam int MAX_A        = (ANNOUNCE_HC > WAIT_HC) ? ANNOUNCE_HC : WAIT_HC;
    localparam int MAX_B        = (COMPLETE_MAX > SPIN_MAX) ? COMPLETE_MAX : SPIN_MAX;
    localparam int MAX_HC       = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W        = $clog2(MAX_HC + 1);

    seq_state_e state, state_n;
    seq_op_e    op;

    logic [ADDR_W-1:0] addr_q;
    logic              space_q;
    logic              done_q;
    logic [DATA_W-1:0] data_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              pc_set;
    logic              pc_step;
    logic              accept;
    logic              finish;
    logic              any_term;
    logic [CNT_W-1:0]  complete_len;
    logic [CNT_W-1:0]  spin_len;
    seq_state_e        rd_entry_state;
    logic [CNT_W-1:0]  rd_entry_len;

    assign op           = seq_op_e'(req_op);
    assign any_term     = mem_dtack | mem_vpa | mem_berr;
    assign complete_len = CNT_W'(COMPLETE_HC - 1) + CNT_W'(mem_extra);
    assign spin_len     = CNT_W'(HC_PER_MC) * CNT_W'(req_mc) - CNT_W'(1);

    generate
        if (IMPLICIT_ACK) begin : g_implicit
            assign rd_entry_state = ST_COMPLETE;
            assign rd_entry_len   = complete_len;
        end else begin : g_handshake
            assign rd_entry_state = ST_ANNOUNCE;
            assign rd_entry_len   = CNT_W'(ANNOUNCE_HC - 1);
        end
    endgenerate

    busseq_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    busseq_pc_unit #(.AW(ADDR_W), .PC_RESET(PC_RESET)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (pc_set),
        .set_val (req_addr),
        .step    (pc_step),
        .pc      (pc)
    );

    // Next state and control strobes
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pc_set   = 1'b0;
        pc_step  = 1'b0;
        accept   = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    unique case (op)
                        OP_DATA_RD, OP_PROG_RD: begin
                            state_n  = rd_entry_state;
                            tmr_load = 1'b1;
                            tmr_val  = rd_entry_len;
                        end
                        OP_BUSIDLE: begin
                            if (req_mc == '0) begin
                                finish = 1'b1;
                            end else begin
                                state_n  = ST_SPIN;
                                tmr_load = 1'b1;
                                tmr_val  = spin_len;
                            end
                        end
                        OP_SET_PC: begin
                            pc_set = 1'b1;
                            finish = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ANNOUNCE, ST_WAIT: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (any_term) begin
                        state_n = ST_COMPLETE;
                        tmr_val = complete_len;
                    end else begin
                        state_n = ST_WAIT;
                        tmr_val = CNT_W'(WAIT_HC - 1);
                    end
                end
            end
            ST_COMPLETE: begin
                if (tmr_zero) begin
                    state_n = ST_IDLE;
                    finish  = 1'b1;
                    pc_step = space_q;
                end
            end
            ST_SPIN: begin
                if (tmr_zero) begin
                    state_n = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and captured access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            space_q <= 1'b0;
            done_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state  <= state_n;
            done_q <= finish;
            if (accept && (op == OP_DATA_RD || op == OP_PROG_RD)) begin
                addr_q  <= (op == OP_PROG_RD) ? pc : req_addr;
                space_q <= (op == OP_PROG_RD);
            end
            if (state == ST_COMPLETE && tmr_zero)
                data_q <= mem_rdata;
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        bus_as    = 1'b0;
        bus_rd    = 1'b0;
        unique case (state)
            ST_IDLE:                         req_ready = 1'b1;
            ST_ANNOUNCE, ST_WAIT, ST_COMPLETE: begin
                bus_as = 1'b1;
                bus_rd = 1'b1;
            end
            ST_SPIN: ;
            default: ;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_space = space_q;
    assign done      = done_q;
    assign done_data = data_q;
endmodule

// File: rtl/busseq_checker.sv
module busseq_checker #(
    parameter int AW     = 24,
    parameter int MIN_AS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          bus_as,
    input logic          bus_space,
    input logic [AW-1:0] bus_addr,
    input logic          done,
    input logic [AW-1:0] pc
);
    logic [7:0] as_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            as_run <= '0;
        else if (!bus_as)
            as_run <= '0;
        else if (as_run != 8'hFF)
            as_run <= as_run + 8'd1;
    end

    assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && bus_as));

    assert_context_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_space)));

    assert_min_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> ($past(as_run) >= 8'(MIN_AS - 1)));

    assert_done_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> done);

    assert_done_strobe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_as);

    assert_pc_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_as) && $past(bus_space)) |-> (pc == $past(pc) + AW'(2)));

    assert_pc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_as) && !$past(bus_space)) |-> $stable(pc));

    assert_ready_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind bus_read_sequencer busseq_checker #(
    .AW     (ADDR_W),
    .MIN_AS (IMPLICIT_ACK ? COMPLETE_HC : ANNOUNCE_HC + COMPLETE_HC)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_as    (bus_as),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .done      (done),
    .pc        (pc)
);

// File: tb/tb_bus_read_sequencer.sv
module tb_bus_read_sequencer;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_mc = '0;
    logic          t_dtack = 1'b0, t_vpa = 1'b0, t_berr = 1'b0;
    logic [2:0]    extra = '0;

    logic          rdy_d, as_d, rd_d, sp_d, done_d;
    logic [AW-1:0] addr_d, pc_d;
    logic [DW-1:0] data_d, mem_d;
    logic          rdy_i, as_i, rd_i, sp_i, done_i;
    logic [AW-1:0] addr_i, pc_i;
    logic [DW-1:0] data_i, mem_i;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign mem_d = mem_word(addr_d);
    assign mem_i = mem_word(addr_i);

    bus_read_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_d),
        .req_op(req_op), .req_addr(req_addr), .req_mc(req_mc),
        .mem_dtack(t_dtack), .mem_vpa(t_vpa), .mem_berr(t_berr),
        .mem_extra(extra), .mem_rdata(mem_d), .bus_addr(addr_d),
        .bus_space(sp_d), .bus_as(as_d), .bus_rd(rd_d), .done(done_d),
        .done_data(data_d), .pc(pc_d)
    );

    bus_read_sequencer #(.IMPLICIT_ACK(1'b1)) dut_imp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_i),
        .req_op(req_op), .req_addr(req_addr), .req_mc(req_mc),
        .mem_dtack(t_dtack), .mem_vpa(t_vpa), .mem_berr(t_berr),
        .mem_extra(extra), .mem_rdata(mem_i), .bus_addr(addr_i),
        .bus_space(sp_i), .bus_as(as_i), .bus_rd(rd_i), .done(done_i),
        .done_data(data_i), .pc(pc_i)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Issue one operation; caller is at a negedge. tsel picks the terminator.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [3:0] mc,
                         input int tsel, input int tstart, input logic [2:0] x, input bit poke);
        int exp_d, exp_i, k, got_d, got_i, c;
        logic [AW-1:0] pc0, ra;
        bit is_rd;
        is_rd = (op == 2'd0 || op == 2'd1);
        pc0 = pc_d;
        ra  = (op == 2'd1) ? pc0 : a;
        k   = (tstart >= 4) ? (tstart - 2) / 2 : 0;
        if (is_rd) begin
            exp_d = 8 + 2 * k + int'(x);
            exp_i = 4 + int'(x);
        end else if (op == 2'd2) begin
            exp_d = 4 * int'(mc);
            exp_i = exp_d;
        end else begin
            exp_d = 0;
            exp_i = 0;
        end
        check(rdy_d && rdy_i, "R11 ready before accept", rdy_d, 1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_mc = mc; extra = x;
        t_dtack = 1'b0; t_vpa = 1'b0; t_berr = 1'b0;
        got_d = -1; got_i = -1;
        @(posedge clk);
        @(negedge clk);
        c = 0;
        forever begin
            if (c == 0 || (poke && c == 3)) req_valid = 1'b0;
            if (done_d && got_d < 0) begin
                got_d = c;
                check(rdy_d, "R11 ready with done", rdy_d, 1);
            end
            if (done_i && got_i < 0) got_i = c;
            if (op == 2'd2) check(!as_d && !as_i, "R9 strobe low during idle op", as_d, 0);
            if (is_rd && c == 1) begin
                check(as_d && rd_d, "R3 strobes up", {as_d, rd_d}, 2'b11);
                check(addr_d == ra, "R3/R8 address", addr_d, ra);
                check(sp_d == (op == 2'd1), "R3 space", sp_d, op == 2'd1);
                check(!rdy_d, "R2 busy not ready", rdy_d, 0);
            end
            if ((got_d >= 0 && got_i >= 0) || c > 100) break;
            t_dtack = (tsel == 0) && (c >= tstart);
            t_vpa   = (tsel == 1) && (c >= tstart);
            t_berr  = (tsel == 2) && (c >= tstart);
            if (poke && c == 2) begin
                req_valid = 1'b1; req_op = 2'd3; req_addr = 24'hFFFFF0;
            end
            @(negedge clk);
            c++;
        end
        if (is_rd)
            check(got_d == exp_d, $sformatf("R4/R5/R6 latency tsel=%0d t=%0d x=%0d", tsel, tstart, x), got_d, exp_d);
        else if (op == 2'd2)
            check(got_d == exp_d, "R9 idle latency", got_d, exp_d);
        else
            check(got_d == exp_d, "R10 set latency", got_d, exp_d);
        check(got_i == exp_i, "R7 implicit latency", got_i, exp_i);
        if (is_rd) begin
            check(data_d == mem_word(ra), "R6 data", data_d, mem_word(ra));
            check(data_i == mem_word(ra), "R7 data", data_i, mem_word(ra));
        end
        if (op == 2'd1) check(pc_d == pc0 + 2, "R8 pc advance", pc_d, pc0 + 2);
        else if (op == 2'd3) check(pc_d == a && pc_i == a, "R10 pc load", pc_d, a);
        else check(pc_d == pc0, "R8/R2 pc unchanged", pc_d, pc0);
        t_dtack = 1'b0; t_vpa = 1'b0; t_berr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rdy_d && !as_d && !rd_d && !done_d, "R1 reset outputs", {rdy_d, as_d, rd_d, done_d}, 4'b1000);
        check(pc_d == 0 && pc_i == 0, "R1 reset pc", pc_d, 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(2'd3, 24'h000100, 4'd0, 0, 0, 3'd0, 1'b0);
        for (int ts = 0; ts < 3; ts++)
            for (int t = 0; t < 8; t++)
                for (int x = 0; x < 4; x++)
                    issue(2'd0, 24'h012340 + 24'(ts * 64 + t * 8 + x * 2), 4'd0, ts, t, 3'(x), 1'b0);
        for (int i = 0; i < 6; i++)
            issue(2'd1, 24'h0, 4'd0, i % 3, i, 3'(i % 4), 1'b0);
        for (int m = 0; m < 6; m++)
            issue(2'd2, 24'h0, 4'(m), 0, 0, 3'd0, 1'b0);
        issue(2'd0, 24'h00ABCE, 4'd0, 0, 5, 3'd1, 1'b1);
        issue(2'd1, 24'h0, 4'd0, 1, 2, 3'd2, 1'b1);
        finish_run();
    end
endmodule